// File: doc/BRIEF.md
# Write leveling training sequencer

This block is the control engine for DDR3 write leveling on one memory channel. After `start` it visits the DIMM slots in ascending order and trains each populated slot. For a slot, it first sends every present rank a mode-register pair that turns leveling on. It then waits for the DRAM to settle and drives the leveling ODT. After a further settle time it holds the PHY train strobe high for a fixed window, then pulses a capture strobe so the PHY can latch its per-lane results. Finally it drops the ODT, waits, and sends the ranks a second mode-register pair that turns leveling off.

While a run is in progress, the sequencer holds automatic refresh off and forces the short ZQ calibration interval to zero. When the run finishes, both are restored. A second leveling pass is only useful when the operating speed is above the start-up speed. For a second-pass request that does not meet this condition, the block reports completion at once and touches nothing. The DRAM, the PHY and all delay arithmetic are outside this block.

Top module: `wrlvl_seq`

## Requirements
- R1: During and after reset, with no start, `busy`, `done`, `wl_odt_en`, `wl_train_en`, `lvl_capture`, `mrs_valid` and `refresh_block` are 0, and `zq_interval` is 2.
- R2: From the cycle after an accepted start until the run ends, `refresh_block` is 1 and `zq_interval` is 0 whenever any command is outstanding. In the `done` cycle, `refresh_block` is 0 and `zq_interval` is 2.
- R3: Slot d is trained only if `cs_enable[2d]` or `cs_enable[2d+1]` is 1. Slots are trained from 0 upward, and `trn_slot` shows the slot being trained.
- R4: Each phase (entry and exit) walks chip-select indices from 0 upward. Each index whose `cs_present` bit is 1 gets MR1 (`mrs_sel`=0) and then MR2 (`mrs_sel`=1). `mrs_lvl_en` is 1 in the entry phase and 0 in the exit phase. Absent chip selects get no command.
- R5: Once `mrs_valid` is raised, it stays high with `mrs_cs`, `mrs_sel` and `mrs_lvl_en` unchanged until `mrs_ready` is seen high.
- R6: `wl_odt_en` rises 41 cycles after the cycle of the last accepted entry-phase command. One more cycle is added for each chip-select index above the highest present one.
- R7: `wl_train_en` rises exactly 10 cycles after `wl_odt_en` rises, and is high only while `wl_odt_en` is high.
- R8: `wl_train_en` stays high for exactly 200 consecutive cycles. `lvl_capture` pulses for one cycle, in the first cycle with `wl_train_en` low, while `wl_odt_en` is still high.
- R9: `wl_odt_en` falls in the cycle after `lvl_capture`. The first exit-phase command appears 10 cycles later, plus one cycle per absent chip-select index below the lowest present one.
- R10: If `pass_sel`=1 and `speed_cur` is not greater than `speed_boot`, `done` comes in the cycle after start, with no command issued and `refresh_block` never set. Pass 1 (`pass_sel`=0), or pass 2 with a higher speed, runs the full sequence.
- R11: `done` is a one-cycle pulse, and `busy` is high from the cycle after start through the `done` cycle. A `start` while `busy` is ignored.
- R12: An unpopulated slot costs one cycle. With all `cs_enable` bits 0, `done` comes NUM_SLOTS+1 cycles after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | memory clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | begin a run (taken when idle) |
| pass_sel | input | 1 | 0 = first pass, 1 = second pass |
| speed_cur | input | SPEED_W | operating speed code |
| speed_boot | input | SPEED_W | start-up speed code |
| cs_enable | input | 2*NUM_SLOTS | enabled chip selects, two per slot |
| cs_present | input | 2*NUM_SLOTS | chip selects that receive mode-register commands |
| mrs_ready | input | 1 | command port accepts the held command |
| mrs_valid | output | 1 | mode-register command offered |
| mrs_cs | output | CS_W | target chip select of the command |
| mrs_sel | output | 1 | 0 = MR1, 1 = MR2 |
| mrs_lvl_en | output | 1 | leveling mode requested in MR1 |
| trn_slot | output | SLOT_W | slot under training |
| wl_odt_en | output | 1 | leveling ODT enable |
| wl_train_en | output | 1 | PHY leveling train strobe |
| lvl_capture | output | 1 | one-cycle result capture strobe |
| refresh_block | output | 1 | automatic refresh suppressed |
| zq_interval | output | ZQ_W | short ZQ calibration interval code |
| busy | output | 1 | run in progress |
| done | output | 1 | run finished (one cycle) |

## Verification
Two events can land in the same cycle: acceptance of the last entry-phase MR2 and the start of the 40-cycle settle timer. Similarly, the end of the ODT-off settle coincides with the first exit command. The bench provokes these with a command port that stalls `mrs_ready` and with sets of present chip selects whose highest and lowest members vary. It judges them by the exact gaps in R6 and R9. A second `start` pulse is also injected during a stalled mode-register phase. Any extra or reordered command it might cause would show up against the scoreboard queue.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_SCAN, ST_MR_ON, ST_MR_WAIT, ST_ODT_ON,
      ST_TRAIN, ST_CAPT, ST_ODT_OFF, ST_MR_OFF, ST_FINISH
   } wl_state_t;

   localparam logic SEL_MR1 = 1'b0;
   localparam logic SEL_MR2 = 1'b1;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/wrlvl_timer.sv
module wrlvl_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/wrlvl_slot_scan.sv
module wrlvl_slot_scan #(
   parameter int NUM_SLOTS = 2,
   parameter int SLOT_W    = 1
) (
   input  logic [2*NUM_SLOTS-1:0] cs_enable,
   input  logic [SLOT_W-1:0]      slot,
   output logic                   populated,
   output logic                   last_slot
);
   logic [NUM_SLOTS-1:0] pop_vec;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign pop_vec[g] = cs_enable[2*g] | cs_enable[2*g+1];
   end

   assign populated = pop_vec[slot];
   assign last_slot = (slot == SLOT_W'(NUM_SLOTS - 1));
endmodule

// File: rtl/wrlvl_mrs_walk.sv
module wrlvl_mrs_walk #(
   parameter int NUM_CS = 4,
   parameter int CS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [NUM_CS-1:0] cs_present,
   input  logic              mrs_ready,
   output logic              mrs_valid,
   output logic [CS_W-1:0]   mrs_cs,
   output logic              mrs_sel,
   output logic              fin
);
   import wrlvl_pkg::*;

   logic            active;
   logic [CS_W-1:0] idx;
   logic            sel;
   logic            here;
   logic            at_end;
   logic            step;

   assign here   = cs_present[idx];
   assign at_end = (idx == CS_W'(NUM_CS - 1));
   // leave an index when it is absent or its MR2 has been taken
   assign step   = active && (!here || (mrs_ready && sel == SEL_MR2));
   assign fin    = step && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         sel    <= SEL_MR1;
      end else if (go) begin
         active <= 1'b1;
         idx    <= '0;
         sel    <= SEL_MR1;
      end else if (active) begin
         if (here && mrs_ready && sel == SEL_MR1) begin
            sel <= SEL_MR2;
         end else if (step) begin
            sel <= SEL_MR1;
            if (at_end) active <= 1'b0;
            else        idx    <= idx + CS_W'(1);
         end
      end
   end

   assign mrs_valid = active && here;
   assign mrs_cs    = idx;
   assign mrs_sel   = sel;

   a_r5_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (mrs_valid && !mrs_ready) |=> (mrs_valid && $stable(mrs_cs) && $stable(mrs_sel)));

   a_r4_only_present: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_valid |-> cs_present[mrs_cs]);
endmodule

// File: rtl/wrlvl_seq.sv
module wrlvl_seq #(
   parameter int NUM_SLOTS    = 2,
   parameter int SPEED_W      = 8,
   parameter int T_MR_SETTLE  = 40,
   parameter int T_ODT_SETTLE = 10,
   parameter int T_TRAIN      = 200,
   parameter int ZQ_W         = 2,
   parameter int ZQ_RESTORE   = 2,
   localparam int NUM_CS      = 2 * NUM_SLOTS,
   localparam int CS_W        = $clog2(NUM_CS),
   localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pass_sel,
   input  logic [SPEED_W-1:0] speed_cur,
   input  logic [SPEED_W-1:0] speed_boot,
   input  logic [NUM_CS-1:0]  cs_enable,
   input  logic [NUM_CS-1:0]  cs_present,
   input  logic               mrs_ready,
   output logic               mrs_valid,
   output logic [CS_W-1:0]    mrs_cs,
   output logic               mrs_sel,
   output logic               mrs_lvl_en,
   output logic [SLOT_W-1:0]  trn_slot,
   output logic               wl_odt_en,
   output logic               wl_train_en,
   output logic               lvl_capture,
   output logic               refresh_block,
   output logic [ZQ_W-1:0]    zq_interval,
   output logic               busy,
   output logic               done
);
   import wrlvl_pkg::*;

   localparam int T_MAX = max3(T_MR_SETTLE, T_ODT_SETTLE, T_TRAIN);
   localparam int TMR_W = $clog2(T_MAX + 1);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("wrlvl_seq: NUM_SLOTS must be at least 1");
   end
   if (T_MR_SETTLE < 1 || T_ODT_SETTLE < 1 || T_TRAIN < 1) begin : g_bad_wait
      $error("wrlvl_seq: every wait must be at least one cycle");
   end
   if (ZQ_RESTORE >= (1 << ZQ_W)) begin : g_bad_zq
      $error("wrlvl_seq: ZQ_RESTORE does not fit ZQ_W");
   end

   wl_state_t         st, st_n;
   logic [SLOT_W-1:0] slot, slot_n;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_zero;
   logic              walk_go;
   logic              walk_fin;
   logic              slot_pop;
   logic              slot_last;
   logic              skip_run;

   assign skip_run = pass_sel && !(speed_cur > speed_boot);

   wrlvl_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   wrlvl_slot_scan #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_scan (
      .cs_enable (cs_enable),
      .slot      (slot),
      .populated (slot_pop),
      .last_slot (slot_last)
   );

   wrlvl_mrs_walk #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (walk_go),
      .cs_present (cs_present),
      .mrs_ready  (mrs_ready),
      .mrs_valid  (mrs_valid),
      .mrs_cs     (mrs_cs),
      .mrs_sel    (mrs_sel),
      .fin        (walk_fin)
   );

   always_comb begin
      st_n     = st;
      slot_n   = slot;
      tmr_load = 1'b0;
      tmr_val  = '0;
      walk_go  = 1'b0;
      unique case (st)
         ST_IDLE: if (start) begin
            slot_n = '0;
            st_n   = skip_run ? ST_FINISH : ST_SCAN;
         end
         ST_SCAN: begin
            if (slot_pop) begin
               st_n    = ST_MR_ON;
               walk_go = 1'b1;
            end else if (slot_last) begin
               st_n = ST_FINISH;
            end else begin
               slot_n = slot + SLOT_W'(1);
            end
         end
         ST_MR_ON: if (walk_fin) begin
            st_n     = ST_MR_WAIT;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_MR_SETTLE - 1);
         end
         ST_MR_WAIT: if (tmr_zero) begin
            st_n     = ST_ODT_ON;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_ODT_SETTLE - 1);
         end
         ST_ODT_ON: if (tmr_zero) begin
            st_n     = ST_TRAIN;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_TRAIN - 1);
         end
         ST_TRAIN: if (tmr_zero) st_n = ST_CAPT;
         ST_CAPT: begin
            st_n     = ST_ODT_OFF;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_ODT_SETTLE - 1);
         end
         ST_ODT_OFF: if (tmr_zero) begin
            st_n    = ST_MR_OFF;
            walk_go = 1'b1;
         end
         ST_MR_OFF: if (walk_fin) begin
            if (slot_last) st_n = ST_FINISH;
            else begin
               st_n   = ST_SCAN;
               slot_n = slot + SLOT_W'(1);
            end
         end
         ST_FINISH: st_n = ST_IDLE;
         default:   st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         slot <= '0;
      end else begin
         st   <= st_n;
         slot <= slot_n;
      end
   end

   assign trn_slot      = slot;
   assign mrs_lvl_en    = (st == ST_MR_ON);
   assign wl_odt_en     = (st == ST_ODT_ON) || (st == ST_TRAIN) || (st == ST_CAPT);
   assign wl_train_en   = (st == ST_TRAIN);
   assign lvl_capture   = (st == ST_CAPT);
   assign busy          = (st != ST_IDLE);
   assign done          = (st == ST_FINISH);
   assign refresh_block = busy && !done;
   assign zq_interval   = refresh_block ? '0 : ZQ_W'(ZQ_RESTORE);

   // checker state: length of the current train-enable run
   logic [TMR_W-1:0] train_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           train_run <= '0;
      else if (wl_train_en) train_run <= train_run + TMR_W'(1);
      else                  train_run <= '0;
   end

   a_r2_cmd_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_valid |-> (refresh_block && zq_interval == '0));

   a_r7_train_in_odt: assert property (@(posedge clk) disable iff (!rst_n)
      wl_train_en |-> wl_odt_en);

   a_r8_train_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wl_train_en) |-> ($past(train_run) == TMR_W'(T_TRAIN - 1)));

   a_r8_capture_after: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_capture |-> ($past(wl_train_en) && !wl_train_en && wl_odt_en));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r10_skip_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && pass_sel && !(speed_cur > speed_boot)) |=> (done && !refresh_block));
endmodule

// File: tb/tb_wrlvl_seq.sv
`timescale 1ns/1ps
module tb_wrlvl_seq;
   localparam int NS  = 2;
   localparam int NCS = 2 * NS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic pass_sel = 1'b0;
   logic [7:0] speed_cur = '0, speed_boot = '0;
   logic [NCS-1:0] cs_enable = '0, cs_present = '0;
   logic mrs_ready = 1'b1;
   logic mrs_valid, mrs_sel, mrs_lvl_en;
   logic [1:0] mrs_cs;
   logic [0:0] trn_slot;
   logic wl_odt_en, wl_train_en, lvl_capture, refresh_block, busy, done;
   logic [1:0] zq_interval;

   wrlvl_seq #(.NUM_SLOTS(NS)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pass_sel(pass_sel),
      .speed_cur(speed_cur), .speed_boot(speed_boot),
      .cs_enable(cs_enable), .cs_present(cs_present), .mrs_ready(mrs_ready),
      .mrs_valid(mrs_valid), .mrs_cs(mrs_cs), .mrs_sel(mrs_sel),
      .mrs_lvl_en(mrs_lvl_en), .trn_slot(trn_slot), .wl_odt_en(wl_odt_en),
      .wl_train_en(wl_train_en), .lvl_capture(lvl_capture),
      .refresh_block(refresh_block), .zq_interval(zq_interval),
      .busy(busy), .done(done));

   always #2.5 clk = ~clk;

   typedef struct { int cs; int sel; int lvl; int slot; } mr_t;
   mr_t mr_q[$];
   int  slot_q[$];

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit stall = 1'b0;
   bit finished = 1'b0;
   bit refresh_seen = 1'b0;
   int done_cnt = 0;
   int exp_on_gap = 0, exp_off_gap = -1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;
   // command-port stub: ready is changed away from the sampling edge
   always @(posedge clk) begin
      #1 mrs_ready = !stall || (cyc % 3 == 2);
   end

   // monitor / scoreboard
   int last_on_acc = 0, odt_rise = 0, train_rise = 0, train_fall = 0;
   int cap_cyc = 0, odt_fall = 0;
   bit odt_d = 0, train_d = 0, exit_pending = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (refresh_block) refresh_seen = 1'b1;
         if (done) done_cnt++;
         if (mrs_valid && !mrs_lvl_en && exit_pending) begin
            exit_pending = 0;
            chk(cyc - odt_fall == exp_off_gap, "R9 exit command gap", cyc - odt_fall, exp_off_gap);
         end
         if (mrs_valid && mrs_ready) begin
            chk(refresh_block && zq_interval == 0, "R2 suppression at command", zq_interval, 0);
            if (mr_q.size() == 0) begin
               chk(1'b0, "R4 unexpected command", mrs_cs, -1);
            end else begin
               mr_t e;
               e = mr_q.pop_front();
               chk(mrs_cs == e.cs, "R4 command chip select", mrs_cs, e.cs);
               chk(mrs_sel == e.sel, "R4 MR1 then MR2 order", mrs_sel, e.sel);
               chk(mrs_lvl_en == e.lvl, "R4 leveling flag", mrs_lvl_en, e.lvl);
               chk(trn_slot == e.slot, "R3 slot during command", trn_slot, e.slot);
            end
            if (mrs_lvl_en) last_on_acc = cyc;
         end
         if (wl_odt_en && !odt_d) begin
            odt_rise = cyc;
            if (exp_on_gap != 0)
               chk(cyc - last_on_acc == exp_on_gap, "R6 settle before ODT", cyc - last_on_acc, exp_on_gap);
         end
         if (wl_train_en && !train_d) begin
            train_rise = cyc;
            chk(cyc - odt_rise == 10, "R7 ODT to train gap", cyc - odt_rise, 10);
            if (slot_q.size() == 0) chk(1'b0, "R3 unexpected slot", trn_slot, -1);
            else begin
               int es;
               es = slot_q.pop_front();
               chk(trn_slot == es, "R3 slot order", trn_slot, es);
            end
         end
         if (!wl_train_en && train_d) begin
            train_fall = cyc;
            chk(cyc - train_rise == 200, "R8 train width", cyc - train_rise, 200);
            chk(lvl_capture && wl_odt_en, "R8 capture after train", lvl_capture, 1);
         end
         if (lvl_capture) cap_cyc = cyc;
         if (!wl_odt_en && odt_d) begin
            odt_fall = cyc;
            exit_pending = 1;
            chk(cyc == cap_cyc + 1, "R9 ODT drop after capture", cyc - cap_cyc, 1);
         end
         odt_d   = wl_odt_en;
         train_d = wl_train_en;
      end
   end

   task automatic run(input bit ps, input int cur, input int boot, input int en,
                      input int pres, input bit stall_i, input bit poke);
      bit skip;
      int hi, lo, t0, t_done, d0;
      skip = ps && !(cur > boot);
      hi = -1; lo = -1;
      for (int c = 0; c < NCS; c++) if (pres[c]) begin hi = c; if (lo < 0) lo = c; end
      exp_on_gap  = (hi < 0) ? 0 : 41 + (NCS - 1 - hi);
      exp_off_gap = (lo < 0) ? -1 : 10 + lo;
      if (!skip) begin
         for (int s = 0; s < NS; s++) begin
            if (en[2*s] || en[2*s+1]) begin
               slot_q.push_back(s);
               for (int ph = 1; ph >= 0; ph--)
                  for (int c = 0; c < NCS; c++)
                     if (pres[c]) begin
                        mr_q.push_back('{c, 0, ph, s});
                        mr_q.push_back('{c, 1, ph, s});
                     end
            end
         end
      end
      @(negedge clk);
      pass_sel = ps; speed_cur = 8'(cur); speed_boot = 8'(boot);
      cs_enable = NCS'(en); cs_present = NCS'(pres); stall = stall_i;
      @(negedge clk);
      refresh_seen = 0; d0 = done_cnt;
      start = 1'b1; t0 = cyc;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      t_done = cyc;
      chk(busy, "R11 busy in done cycle", busy, 1);
      chk(!refresh_block && zq_interval == 2, "R2 restore at done", zq_interval, 2);
      if (skip) begin
         chk(t_done == t0 + 1, "R10 immediate done", t_done - t0, 1);
         chk(!refresh_seen, "R10 no suppression on skip", refresh_seen, 0);
      end
      if (!skip && en == 0)
         chk(t_done == t0 + 1 + NS, "R12 empty slots cost", t_done - t0, 1 + NS);
      chk(mr_q.size() == 0, "R4 all commands seen", mr_q.size(), 0);
      chk(slot_q.size() == 0, "R3 all slots trained", slot_q.size(), 0);
      @(negedge clk);
      chk(!done && !busy, "R11 done is one cycle", done, 0);
      repeat (10) @(negedge clk);
      chk(done_cnt - d0 == 1, "R11 one done per run", done_cnt - d0, 1);
      mr_q.delete(); slot_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mrs_valid && !refresh_block, "R1 reset outputs", busy, 0);
      chk(zq_interval == 2, "R1 reset ZQ code", zq_interval, 2);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!wl_odt_en && !wl_train_en && !lvl_capture && !busy, "R1 idle outputs", wl_odt_en, 0);
      run(0, 4, 4, 'b0011, 'b0011, 0, 0);    // slot 0 only, fast port
      run(0, 4, 4, 'b1100, 'b1111, 1, 0);    // slot 1 only, stalled port
      run(0, 4, 4, 'b1001, 'b1010, 1, 1);    // both slots, sparse ranks, restart poke
      run(1, 10, 10, 'b1111, 'b1111, 0, 0);  // equal speeds: R10 skip
      run(1, 5, 10, 'b0011, 'b0011, 0, 0);   // slower: R10 skip
      run(1, 11, 10, 'b0100, 'b0100, 0, 0);  // faster: R10 full second pass
      run(0, 4, 4, 'b0000, 'b0011, 0, 0);    // R12 no populated slot
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule